// File: doc/BRIEF.md
# PHY Control-Bus Handshake Master

This block carries register accesses from a host-side command port onto the internal control bus of a serial-link PHY. Three access kinds are offered: load an address, write a data word, and read a data word. Every access is a sequence of strobes toward the PHY. Each strobe is raised and held until the PHY acknowledge goes high. It is then dropped and the block waits until the acknowledge goes low again. Reads capture the PHY output word while the acknowledge is high.

The acknowledge is not watched continuously. It is polled once every `POLL_GAP` clock cycles, and at most `MAX_POLLS` times for each edge. If the expected level never appears, the access ends with an error. A write whose data has bit 0 set asks the PHY to reset itself. The PHY cannot acknowledge during its reset, so the write strobe is raised and the access ends at once. A fourth command drives the PHY power-down test line, which stays set until the block itself is reset.

Top module: `phy_cr_master`

## Requirements
- R1: While `rst_n` is low, and after it is released, all five PHY control lines are 0, and `busy`, `done` and `err` are 0.
- R2: A command is taken only when `cmd_valid` is high and `busy` is low. A `cmd_valid` raised while `busy` is high is ignored: it produces no strobe and no `done`.
- R3: Opcode 0 (address) drives `cmd_data` on `phy_din` and runs one full handshake on `phy_cap_addr`.
- R4: Opcode 1 (write) drives `cmd_data` on `phy_din`. It runs a full handshake on `phy_cap_data` and then a full handshake on `phy_wr`.
- R5: If bit 0 of the write data is 1, `phy_wr` is raised after the `phy_cap_data` handshake and `done` follows with no acknowledge wait. `phy_wr` stays high until the next command is taken.
- R6: Opcode 2 (read) runs a full handshake on `phy_rd`. `rd_data` takes `phy_dout` as sampled on the poll that sees the acknowledge high.
- R7: At most one of `phy_cap_addr`, `phy_cap_data`, `phy_wr` and `phy_rd` is high at a time. A strobe is dropped only after a poll has seen the acknowledge high. The next strobe of an access is raised only after a poll has seen it low.
- R8: The acknowledge is polled every `POLL_GAP` cycles, at most `MAX_POLLS` times per edge. If the level is seen on the last permitted poll, the access succeeds. If it is not seen by then, all strobes drop and `done` pulses with `err` high.
- R9: `done` is a one-cycle pulse at the end of each command, with `busy` low. `err` is high only together with `done`.
- R10: Opcode 3 (power-down) sets `phy_pwrdn` and pulses `done` without error on the next cycle. `phy_pwrdn` stays at 1 until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 power-down |
| cmd_data | input | 16 | Address or write data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Acknowledge timeout, valid with done |
| rd_data | output | 16 | Word captured by the last read |
| phy_din | output | 16 | Data-in bus to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_pwrdn | output | 1 | Power-down test line |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | 16 | PHY read data |

## Verification
The acknowledge can arrive on the very poll that also uses up the poll budget, so the success and timeout decisions fall in the same cycle. The bench's PHY model raises its acknowledge a set number of cycles after a strobe. One delay is chosen so that the level appears just before the final poll, and another so that it appears just after that poll. The first case must finish without error and with the correct read word. The second must pulse `done` with `err` and leave every strobe low.

// File: rtl/phy_cr_pkg.sv
// Shared opcodes and strobe indices for the PHY control-bus master.
// Assumes a 2-bit opcode field on the command port.
package phy_cr_pkg;
    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_PWRDN = 2'd3
    } cr_op_e;

    // Bit positions inside the handshake strobe vector.
    localparam int STB_ADDR = 0;
    localparam int STB_DATA = 1;
    localparam int STB_WR   = 2;
    localparam int STB_RD   = 3;
    localparam int STB_N    = 4;
endpackage

// File: rtl/phy_cr_poll_timer.sv
// Poll pacing for acknowledge checks: fires 'sample' once every GAP cycles
// while 'run' is high, and flags the sample that exhausts the poll budget.
// Assumes GAP >= 2 and POLLS >= 1; 'restart' wins over counting.
module phy_cr_poll_timer #(
    parameter int GAP   = 15000,
    parameter int POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic sample,
    output logic last
);
    localparam int GW = $clog2(GAP + 1);
    localparam int PW = $clog2(POLLS + 1);

    logic [GW-1:0] gap_cnt;
    logic [PW-1:0] poll_cnt;

    // Gap counter wraps each GAP cycles; poll counter counts samples taken.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            gap_cnt  <= '0;
            poll_cnt <= '0;
        end else if (run) begin
            if (gap_cnt == GW'(GAP - 1)) begin
                gap_cnt  <= '0;
                poll_cnt <= poll_cnt + 1'b1;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // Sample strobe and budget-exhausted flag.
    always_comb begin
        sample = run && (gap_cnt == GW'(GAP - 1));
        last   = sample && (poll_cnt == PW'(POLLS - 1));
    end
endmodule

// File: rtl/phy_cr_seq.sv
// Strobe sequencer: turns one command into a series of four-phase
// handshakes, captures read data, and reports done/err.
// Assumes the poll timer supplies 'sample'/'last' and is restarted here.
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_dout,
    input  logic              sample,
    input  logic              last,
    output logic              restart,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] din,
    output logic [STB_N-1:0]  stb,
    output logic              pwrdn
);
    typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} state_e;

    state_e     state;
    logic [1:0] step;
    logic       accept;
    logic       hit;

    // Command acceptance, expected-level match and timer control.
    always_comb begin
        accept  = cmd_valid && (state == S_IDLE);
        hit     = (state == S_HI) ? phy_ack : !phy_ack;
        run     = (state != S_IDLE);
        restart = accept || (sample && hit);
        busy    = (state != S_IDLE);
    end

    // Handshake state machine and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            step    <= 2'(STB_ADDR);
            stb     <= '0;
            din     <= '0;
            rd_data <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            pwrdn   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                S_IDLE: if (accept) begin
                    stb <= '0;
                    din <= cmd_data;
                    unique case (cr_op_e'(cmd_op))
                        OP_ADDR:  begin stb[STB_ADDR] <= 1'b1; step <= 2'(STB_ADDR); state <= S_HI; end
                        OP_WRITE: begin stb[STB_DATA] <= 1'b1; step <= 2'(STB_DATA); state <= S_HI; end
                        OP_READ:  begin stb[STB_RD]   <= 1'b1; step <= 2'(STB_RD);   state <= S_HI; end
                        OP_PWRDN: begin pwrdn <= 1'b1; done <= 1'b1; end
                    endcase
                end
                S_HI: if (sample) begin
                    if (phy_ack) begin
                        if (step == 2'(STB_RD)) rd_data <= phy_dout;
                        stb   <= '0;
                        state <= S_LO;
                    end else if (last) begin
                        stb   <= '0;
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_LO: if (sample) begin
                    if (!phy_ack) begin
                        if (step == 2'(STB_DATA)) begin
                            stb[STB_WR] <= 1'b1;
                            step        <= 2'(STB_WR);
                            if (din[0]) begin
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                state <= S_HI;
                            end
                        end else begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                    end else if (last) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_cr_master.sv
// Top of the PHY control-bus handshake master: command port on one side,
// strobes/acknowledge of the PHY control bus on the other.
// Assumes phy_ack and phy_dout are synchronous to clk.
module phy_cr_master #(
    parameter int DATA_W    = 16,
    parameter int POLL_GAP  = 15000,
    parameter int MAX_POLLS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] phy_din,
    output logic              phy_cap_addr,
    output logic              phy_cap_data,
    output logic              phy_wr,
    output logic              phy_rd,
    output logic              phy_pwrdn,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_dout
);
    import phy_cr_pkg::*;

    logic             t_restart;
    logic             t_run;
    logic             t_sample;
    logic             t_last;
    logic [STB_N-1:0] stb;

    phy_cr_poll_timer #(.GAP(POLL_GAP), .POLLS(MAX_POLLS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (t_restart),
        .run     (t_run),
        .sample  (t_sample),
        .last    (t_last)
    );

    phy_cr_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .phy_ack   (phy_ack),
        .phy_dout  (phy_dout),
        .sample    (t_sample),
        .last      (t_last),
        .restart   (t_restart),
        .run       (t_run),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data),
        .din       (phy_din),
        .stb       (stb),
        .pwrdn     (phy_pwrdn)
    );

    // Map the strobe vector onto the PHY pins.
    always_comb begin
        phy_cap_addr = stb[STB_ADDR];
        phy_cap_data = stb[STB_DATA];
        phy_wr       = stb[STB_WR];
        phy_rd       = stb[STB_RD];
    end
endmodule

// File: rtl/phy_cr_master_chk.sv
// Protocol checker for phy_cr_master, attached by bind below.
// Assumes the bench holds rst_n low from time zero.
module phy_cr_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic phy_cap_addr,
    input logic phy_cap_data,
    input logic phy_wr,
    input logic phy_rd,
    input logic phy_pwrdn,
    input logic phy_ack
);
    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));

    // R7: a strobe drops only after a poll saw acknowledge high (timeout excepted)
    assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(phy_cap_addr) || $fell(phy_cap_data) || $fell(phy_rd)) && !(done && err))
        |-> $past(phy_ack));

    // R7: the second strobe of a write rises only after acknowledge went low
    assert_wr_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_wr) && $past(busy)) |-> !$past(phy_ack));

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_pwrdn_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(phy_pwrdn));
endmodule

bind phy_cr_master phy_cr_master_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .phy_cap_addr (phy_cap_addr),
    .phy_cap_data (phy_cap_data),
    .phy_wr       (phy_wr),
    .phy_rd       (phy_rd),
    .phy_pwrdn    (phy_pwrdn),
    .phy_ack      (phy_ack)
);

// File: tb/tb_phy_cr_master.sv
module tb_phy_cr_master;
    localparam int GAP   = 4;
    localparam int POLLS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        busy, done, err;
    logic [15:0] rd_data, phy_din;
    logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_pwrdn;
    logic        phy_ack;
    logic [15:0] phy_dout;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int done_cnt = 0;

    always #5 clk = ~clk;

    phy_cr_master #(.DATA_W(16), .POLL_GAP(GAP), .MAX_POLLS(POLLS)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .phy_din(phy_din), .phy_cap_addr(phy_cap_addr),
        .phy_cap_data(phy_cap_data), .phy_wr(phy_wr), .phy_rd(phy_rd),
        .phy_pwrdn(phy_pwrdn), .phy_ack(phy_ack), .phy_dout(phy_dout)
    );

    // ---------------- PHY model ----------------
    int          dly = 2;
    int          hi_cnt = 0, lo_cnt = 0;
    logic        m_ack = 1'b0;
    logic [15:0] m_addr = '0, m_data = '0, m_wr_data = '0;
    int          m_wr_cnt = 0, m_rst_cnt = 0;
    logic        p_ca = 0, p_cd = 0, p_wr = 0;
    logic        stb_any;

    assign stb_any  = phy_cap_addr | phy_cap_data | phy_rd | (phy_wr & ~m_data[0]);
    assign phy_ack  = m_ack;
    assign phy_dout = m_addr ^ 16'hA5C3;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        p_ca <= phy_cap_addr; p_cd <= phy_cap_data; p_wr <= phy_wr;
        if (phy_cap_addr && !p_ca) m_addr <= phy_din;
        if (phy_cap_data && !p_cd) m_data <= phy_din;
        if (phy_wr && !p_wr) begin
            if (m_data[0]) m_rst_cnt <= m_rst_cnt + 1;
            else begin m_wr_data <= m_data; m_wr_cnt <= m_wr_cnt + 1; end
        end
        if (stb_any) begin
            lo_cnt <= 0;
            if (hi_cnt >= dly - 1) m_ack <= 1'b1; else hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= 0;
            if (lo_cnt >= dly - 1) m_ack <= 1'b0; else lo_cnt <= lo_cnt + 1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic        err;
        logic        chk_rd;
        logic [15:0] rd;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops one expected item per done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(err == e.err, e.req, "err", 32'(err), 32'(e.err));
                if (e.chk_rd) check(rd_data == e.rd, e.req, "rd_data", 32'(rd_data), 32'(e.rd));
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [15:0] data,
                         input logic e_err, input logic e_chk, input logic [15:0] e_rd,
                         input string req);
        exp_t e;
        int start;
        e.err = e_err; e.chk_rd = e_chk; e.rd = e_rd; e.req = req;
        exp_q.push_back(e);
        start = done_cnt;
        @(negedge clk);
        cmd_op = op; cmd_data = data; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 2000 && done_cnt == start; i++) @(negedge clk);
        if (done_cnt == start) check(1'b0, req, "watchdog no done", 32'd0, 32'd1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        check(1'b0, "ALL", "global watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t0;
        int seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_pwrdn} == 5'b0, "R1",
              "strobes in reset", 32'({phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_pwrdn}), 0);
        check({busy, done, err} == 3'b0, "R1", "status in reset", 32'({busy, done, err}), 0);
        rst_n = 1'b1;
        idle(2);
        check({phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_pwrdn, busy} == 6'b0, "R1",
              "after release", 32'({phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_pwrdn, busy}), 0);

        // R3: address access
        issue(2'd0, 16'h2003, 1'b0, 1'b0, 16'h0, "R3");
        check(m_addr == 16'h2003, "R3", "captured addr", 32'(m_addr), 32'h2003);
        check({phy_cap_addr, busy} == 2'b0, "R3", "idle after addr", 32'({phy_cap_addr, busy}), 0);

        // R6: read returns PHY word
        issue(2'd2, 16'h0, 1'b0, 1'b1, 16'h2003 ^ 16'hA5C3, "R6");
        check(phy_rd == 1'b0, "R6", "read strobe low", 32'(phy_rd), 0);

        // R4: normal write, two handshakes
        issue(2'd0, 16'h0034, 1'b0, 1'b0, 16'h0, "R3");
        issue(2'd1, 16'h00F0, 1'b0, 1'b0, 16'h0, "R4");
        check(m_wr_data == 16'h00F0, "R4", "written data", 32'(m_wr_data), 32'h00F0);
        check(m_wr_cnt == 1, "R4", "write strobe count", 32'(m_wr_cnt), 1);
        check(phy_wr == 1'b0, "R4", "write strobe released", 32'(phy_wr), 0);

        // R5: reset-bit write ends without waiting on the write strobe
        idle(3);
        t0 = cyc;
        issue(2'd1, 16'h0001, 1'b0, 1'b0, 16'h0, "R5");
        check((cyc - t0) <= 12, "R5", "reset write latency", 32'(cyc - t0), 12);
        check(phy_wr == 1'b1, "R5", "write held", 32'(phy_wr), 1);
        idle(20);
        check(phy_wr == 1'b1 && !busy, "R5", "write still held", 32'(phy_wr), 1);
        check(m_rst_cnt == 1, "R5", "reset request seen", 32'(m_rst_cnt), 1);
        issue(2'd0, 16'h0055, 1'b0, 1'b0, 16'h0, "R5");
        check(phy_wr == 1'b0, "R5", "write dropped by next command", 32'(phy_wr), 0);

        // R2: command while busy is ignored
        exp_q.push_back('{1'b0, 1'b1, 16'h0055 ^ 16'hA5C3, "R2"});
        seen = done_cnt;
        @(negedge clk); cmd_op = 2'd2; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        idle(3);
        cmd_op = 2'd0; cmd_data = 16'hDEAD; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        idle(60);
        check(done_cnt == seen + 1, "R2", "done count", 32'(done_cnt - seen), 1);
        check(m_addr == 16'h0055, "R2", "addr untouched", 32'(m_addr), 32'h0055);

        // R8: acknowledge on the last poll still succeeds
        dly = 10;
        idle(4);
        issue(2'd2, 16'h0, 1'b0, 1'b1, 16'h0055 ^ 16'hA5C3, "R8");
        // R8: acknowledge just after the last poll times out
        dly = 13;
        idle(4);
        issue(2'd0, 16'h0777, 1'b1, 1'b0, 16'h0, "R8");
        check({phy_cap_addr, phy_cap_data, phy_wr, phy_rd} == 4'b0, "R8", "strobes after timeout",
              32'({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}), 0);
        dly = 2;
        idle(20);

        // R9: done lasts one cycle
        issue(2'd0, 16'h0011, 1'b0, 1'b0, 16'h0, "R9");
        check(done == 1'b0 && err == 1'b0, "R9", "done single cycle", 32'({done, err}), 0);

        // R10: power-down is sticky until reset
        issue(2'd3, 16'h0, 1'b0, 1'b0, 16'h0, "R10");
        check(phy_pwrdn == 1'b1, "R10", "pwrdn set", 32'(phy_pwrdn), 1);
        issue(2'd0, 16'h0022, 1'b0, 1'b0, 16'h0, "R10");
        check(phy_pwrdn == 1'b1, "R10", "pwrdn held", 32'(phy_pwrdn), 1);
        rst_n = 1'b0;
        idle(2);
        check(phy_pwrdn == 1'b0, "R10", "pwrdn cleared by reset", 32'(phy_pwrdn), 0);
        check(exp_q.size() == 0, "R9", "pending expectations", 32'(exp_q.size()), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule